// File: doc/BRIEF.md
# Weighted Two-Class Channel Arbiter

This block decides which of several DMA channels may use a single shared transfer engine. Each channel raises a request line. Each channel also holds two settings: a one-bit service class (urgent or normal) and a 4-bit weight. Only one channel holds the engine at a time. The holder keeps it until the engine pulses `quantum_done`, which marks the end of one service quantum.

Urgent channels are always served ahead of normal ones. Inside a class, service is shared in proportion to the weights. A channel that wins the turn gets a credit equal to its weight, and it keeps the grant for that many quanta. The turn then passes to the next requesting channel of the same class, in ascending index order with wraparound. Each class keeps its own turn pointer. Settings are written one channel at a time through a simple write strobe with an index.

Top module: `prio_wrr_arbiter`

## Requirements
- R1: After reset, `grant` is all zeros, every channel is in the normal class (class bit 0) with weight 1, and both turn pointers point at channel 0.
- R2: `grant` always has at most one bit set. Bit i set means channel i holds the engine.
- R3: At a decision point, any requesting urgent channel (class bit 1) wins over every normal channel (class bit 0). This includes taking the engine from a normal holder that still has credit left.
- R4: Within a class, a channel with weight w (values 1 to 15) that requests without a break gets w back-to-back quanta, and then the turn passes on.
- R5: A weight field of 0 behaves exactly like a weight of 1.
- R6: When a channel gives up the grant, its class pointer moves to the channel after it. The next winner of that class is the first requesting channel found from the pointer, in ascending index order with wraparound.
- R7: Decision points are a `quantum_done` pulse while a grant is held, and any cycle with no grant held. The new grant appears one cycle after the decision edge. At all other times `grant` holds its value, whatever the requests do. A `quantum_done` pulse with no grant held has no effect.
- R8: If the holder's request is low when `quantum_done` pulses, the holder forfeits its remaining credit. When it wins again, it receives its full weight.
- R9: If no channel requests at a decision point, `grant` becomes all zeros.
- R10: A cycle with `cfg_wr` high stores `cfg_urgent` and `cfg_weight` for channel `cfg_sel`. A changed class counts from the next decision. A changed weight is loaded when that channel next wins the turn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | NCH | Per-channel request lines |
| cfg_wr | input | 1 | Setting write strobe |
| cfg_sel | input | $clog2(NCH) | Channel index for the setting write |
| cfg_urgent | input | 1 | Class to store: 1 urgent, 0 normal |
| cfg_weight | input | WBITS | Weight to store; 0 is taken as 1 |
| quantum_done | input | 1 | One-cycle pulse: the holder has finished one quantum |
| grant | output | NCH | One-hot grant, or zero when idle |

## Verification
The hardest case to reach from the ports is a release that happens for a reason other than spent credit. One such case is an urgent request that takes the engine from a normal holder that still has quanta left. Another is a holder that drops its request just before `quantum_done`. In both cases the later order depends on where the pointer went and on whether the credit was reloaded.

The bench builds these cases on purpose. It changes `req` on the falling edge just before a `quantum_done` pulse, then checks the full run lengths that follow. On top of that, the bench sweeps every pair of weights from 1 to 15 for two normal channels. For each pair it compares the whole grant sequence over two complete rounds against the quanta counts computed in the bench.

// File: rtl/prio_wrr_arbiter.sv
module prio_wrr_arbiter #(
  parameter int NCH   = 6,
  parameter int WBITS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NCH-1:0]         req,
  input  logic                   cfg_wr,
  input  logic [$clog2(NCH)-1:0] cfg_sel,
  input  logic                   cfg_urgent,
  input  logic [WBITS-1:0]       cfg_weight,
  input  logic                   quantum_done,
  output logic [NCH-1:0]         grant
);
  localparam int IW = $clog2(NCH);

  logic [NCH-1:0]   urgent_r;
  logic [WBITS-1:0] weight_r [NCH];
  logic [NCH-1:0]   grant_r;
  logic [IW-1:0]    hold_idx;
  logic [WBITS-1:0] credit;
  logic [IW-1:0]    ptr_u, ptr_n;

  logic active, decide, hold_req, hold_urg, keep, release_now;
  logic [NCH-1:0] cand_u, cand_n, pool;
  logic use_u;
  logic [IW-1:0] after_hold, ptr_u_nx, ptr_n_nx, start;
  logic found;
  logic [IW-1:0] pick_idx;
  logic [WBITS-1:0] pick_wt;

  assign grant       = grant_r;
  assign active      = |grant_r;
  assign decide      = !active || quantum_done;
  assign hold_req    = req[hold_idx];
  assign hold_urg    = urgent_r[hold_idx];
  assign cand_u      = req & urgent_r;
  assign cand_n      = req & ~urgent_r;
  assign use_u       = |cand_u;
  assign keep        = hold_req && (credit > WBITS'(1)) && !(!hold_urg && use_u);
  assign release_now = active && quantum_done && !keep;
  assign after_hold  = (hold_idx == IW'(NCH-1)) ? '0 : hold_idx + IW'(1);
  assign ptr_u_nx    = (release_now && hold_urg)  ? after_hold : ptr_u;
  assign ptr_n_nx    = (release_now && !hold_urg) ? after_hold : ptr_n;
  assign pool        = use_u ? cand_u : cand_n;
  assign start       = use_u ? ptr_u_nx : ptr_n_nx;

  always_comb begin
    found    = 1'b0;
    pick_idx = '0;
    for (int k = 0; k < NCH; k++) begin
      int s;
      s = int'(start) + k;
      if (s >= NCH) s = s - NCH;
      if (!found && pool[s]) begin
        found    = 1'b1;
        pick_idx = IW'(s);
      end
    end
  end

  assign pick_wt = (weight_r[pick_idx] == '0) ? WBITS'(1) : weight_r[pick_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      urgent_r <= '0;
      for (int i = 0; i < NCH; i++) weight_r[i] <= WBITS'(1);
    end else if (cfg_wr && int'(cfg_sel) < NCH) begin
      urgent_r[cfg_sel] <= cfg_urgent;
      weight_r[cfg_sel] <= cfg_weight;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_r  <= '0;
      hold_idx <= '0;
      credit   <= '0;
      ptr_u    <= '0;
      ptr_n    <= '0;
    end else if (decide) begin
      ptr_u <= ptr_u_nx;
      ptr_n <= ptr_n_nx;
      if (active && keep) begin
        credit <= credit - WBITS'(1);
      end else if (found) begin
        grant_r  <= NCH'(1) << pick_idx;
        hold_idx <= pick_idx;
        credit   <= pick_wt;
      end else begin
        grant_r <= '0;
        credit  <= '0;
      end
    end
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_r)); // R2
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !quantum_done) |=> (grant_r == $past(grant_r))); // R7
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && !(|req)) |=> (grant_r == '0)); // R9
  AST_URGENT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && |(req & urgent_r)) |=> |(grant_r & $past(urgent_r))); // R3
  AST_NEW_GRANT_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && |req) |=> |(grant_r & $past(req))); // R6
  AST_CREDIT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (credit != '0)); // R4
endmodule

// File: tb/sim_prio_wrr_arbiter.sv
`timescale 1ns/1ps
module sim_prio_wrr_arbiter;
  localparam int NCH = 6;
  logic clk = 0, rst_n = 0;
  logic [NCH-1:0] req = '0;
  logic cfg_wr = 0, cfg_urgent = 0, quantum_done = 0;
  logic [2:0] cfg_sel = '0;
  logic [3:0] cfg_weight = '0;
  logic [NCH-1:0] grant;
  int nchk = 0, nfail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  prio_wrr_arbiter #(.NCH(NCH), .WBITS(4)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_urgent(cfg_urgent), .cfg_weight(cfg_weight),
    .quantum_done(quantum_done), .grant(grant));

  function automatic int idx_of(logic [NCH-1:0] g);
    int r = -1;
    if ($countones(g) > 1) return -2;
    for (int i = 0; i < NCH; i++) if (g[i]) r = i;
    return r;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expect_g(string tag, int exp);
    int a = idx_of(grant);
    check(a == exp, tag, a, exp);
  endtask

  task automatic do_reset();
    rst_n = 0; req = '0; quantum_done = 0; cfg_wr = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic cfg(int ch, bit urg, int w);
    cfg_wr = 1; cfg_sel = 3'(ch); cfg_urgent = urg; cfg_weight = 4'(w);
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic quantum(output int g);
    g = idx_of(grant);
    quantum_done = 1;
    @(negedge clk);
    quantum_done = 0;
  endtask

  initial begin
    int g;
    do_reset();
    expect_g("R1 idle after reset", -1);
    req = 6'b000011;
    @(negedge clk);
    expect_g("R1 default first winner", 0);
    quantum(g);
    expect_g("R1 default weight one passes turn", 1);
    quantum(g);
    expect_g("R1 default wraps back", 0);

    for (int w0 = 1; w0 <= 15; w0++) begin
      for (int w1 = 1; w1 <= 15; w1++) begin
        do_reset();
        cfg(0, 0, w0); cfg(1, 0, w1);
        req = 6'b000011;
        @(negedge clk);
        for (int q = 0; q < 2 * (w0 + w1); q++) begin
          quantum(g);
          check(g == (((q % (w0 + w1)) < w0) ? 0 : 1), "R4 weighted run", g,
                ((q % (w0 + w1)) < w0) ? 0 : 1);
          check(g >= 0, "R2 single holder", g, 0);
        end
      end
    end

    do_reset();
    cfg(0, 0, 0); cfg(1, 0, 0);
    req = 6'b000011;
    @(negedge clk);
    for (int q = 0; q < 6; q++) begin
      quantum(g);
      check(g == (q % 2), "R5 zero weight acts as one", g, q % 2);
    end

    do_reset();
    for (int c = 0; c < 4; c++) cfg(c, 1, 1);
    req = 6'b001111;
    @(negedge clk);
    for (int q = 0; q < 6; q++) begin
      quantum(g);
      check(g == (q % 4), "R6 ascending rotation", g, q % 4);
    end
    expect_g("R6 holder before release", 2);
    quantum(g);
    expect_g("R6 pointer past holder", 3);
    req = 6'b001001;
    quantum(g);
    expect_g("R6 skip non-requester", 0);
    quantum(g);
    expect_g("R6 wrap to remaining", 3);

    do_reset();
    cfg(0, 0, 4); cfg(1, 0, 4);
    req = 6'b000011;
    @(negedge clk);
    quantum(g);
    expect_g("R8 holder keeps with credit", 0);
    req = 6'b000010;
    quantum(g);
    expect_g("R8 dropped holder loses turn", 1);
    req = 6'b000011;
    for (int q = 0; q < 4; q++) begin
      quantum(g);
      check(g == 1, "R8 other channel full run", g, 1);
    end
    for (int q = 0; q < 4; q++) begin
      quantum(g);
      check(g == 0, "R8 full credit after forfeit", g, 0);
    end
    expect_g("R8 turn passes again", 1);

    do_reset();
    cfg(0, 0, 3); cfg(2, 1, 1);
    req = 6'b000001;
    @(negedge clk);
    expect_g("R7 first grant", 0);
    req = 6'b000111;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      expect_g("R7 grant held without done", 0);
    end
    quantum(g);
    expect_g("R3 urgent takes engine from normal holder", 2);
    req = 6'b000011;
    quantum(g);
    expect_g("R6 normal pointer moved past preempted holder", 1);
    cfg(0, 1, 1);
    quantum(g);
    expect_g("R10 class change counts at next decision", 0);

    do_reset();
    quantum_done = 1;
    @(negedge clk);
    quantum_done = 0;
    expect_g("R7 done without grant ignored", -1);
    req = 6'b000100;
    @(negedge clk);
    expect_g("R7 grant appears one cycle after idle decision", 2);
    req = '0;
    quantum(g);
    expect_g("R9 no requester gives zero grant", -1);

    do_reset();
    cfg(4, 0, 2);
    req = 6'b110000;
    @(negedge clk);
    for (int q = 0; q < 6; q++) begin
      quantum(g);
      check(g == (((q % 3) < 2) ? 4 : 5), "R10 written weight used", g,
            ((q % 3) < 2) ? 4 : 5);
    end

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule